// File: doc/BRIEF.md
# Serial Flash Command Controller

This block is the device side of a small serial flash. It receives instructions from an SPI host (mode 0, most significant bit first) and executes them on an on-chip byte array. By default the array is 1024 bytes, with 256-byte pages and 512-byte sectors. Before the block runs a program or erase, it checks three things: the write-enable latch, the internal busy cycle, and the deep power-down state. Bits can only be cleared by programming. Erasing returns bytes to FFh.

All SPI inputs are oversampled by the system clock. A program or erase does not start until chip select rises after whole bytes. The internal cycle then runs for one system clock per byte of the target region, and the status register reports it as busy for that whole time. The host polls the status byte to find out when the cycle has finished.

Top module: `spi_flash_ctrl`

## Requirements
- R1: The block is selected while `csn_i` is low. Raising `csn_i` ends the frame and discards any partial byte. A single-byte instruction takes effect only if chip select rises after a whole number of bytes.
- R2: Opcode 05h returns the status byte repeatedly until chip select rises. Bit 0 of the status byte is the busy bit and bit 1 is the write-enable latch; all other bits read 0. Opcode 06h sets the write-enable latch. Both status bits are 0 after reset.
- R3: Opcode 02h, followed by a 3-byte address (most significant byte first) and data bytes, programs each byte as old AND new. If the data runs past the end of a 256-byte page, the address wraps to the start of that same page.
- R4: Opcode D8h with a 3-byte address sets every byte of the enclosing 512-byte sector to FFh and leaves other sectors unchanged. Opcode C7h sets every byte of the whole array to FFh.
- R5: A program or erase sent while the write-enable latch is clear is ignored: the busy bit stays 0 and the array is unchanged.
- R6: When an accepted program or erase instruction completes, the busy bit is set. It stays set through the internal cycle. While it is set, every opcode except 05h is ignored.
- R7: The write-enable latch is cleared when a program or erase cycle finishes, so the status reads 00h afterwards.
- R8: Opcode B9h enters deep power-down. In that state every opcode except ABh is ignored, including status reads, which return 00h. Opcode ABh leaves deep power-down and keeps the write-enable latch.
- R9: A program or erase whose chip-select rise does not fall on a byte boundary is discarded. The write-enable latch stays set.
- R10: Opcode 03h with a 3-byte address returns array bytes from that address upward. The address wraps from the last byte of the array to byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |

## Verification
On every cycle, the assertions check how the write-enable latch relates to the busy cycle and to deep power-down. A cycle can only start with the latch set. The latch stays set for the whole cycle and clears at its end. The block is never busy while powered down, and the latch cannot change in that state.

Only the bench's scenarios can show the data behaviour: AND-only programming with page wrap, sector and whole-array erase contents, the read address wrap, and instructions that are discarded for framing, missing latch, busy or power-down. The bench shows this by reading the array back through the serial port and comparing it against a byte model.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;

  localparam int ST_WIP = 0;
  localparam int ST_WEL = 1;
  localparam int HDR_BYTES = 4;  // opcode + 3 address bytes
endpackage

// File: rtl/sfc_spi_front.sv
module sfc_spi_front import sfc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       cs_rise_o,
  output logic       byte_done_o,
  output logic       load_o,
  output logic       aligned_o,
  output logic [7:0] byte_o,
  output logic [2:0] byte_idx_o,
  output logic       miso_o
);
  logic [1:0] sck_sy, csn_sy, mosi_sy;
  logic       sck_d, csn_d;
  logic       sck_s, csn_s, mosi_s, rise, fall;
  logic [6:0] sh_q;
  logic [2:0] bit_q, idx_q;
  logic       pend_q;
  logic [7:0] tx_q;

  assign sck_s  = sck_sy[1];
  assign csn_s  = csn_sy[1];
  assign mosi_s = mosi_sy[1];
  assign rise   = sck_s & ~sck_d & ~csn_s;
  assign fall   = ~sck_s & sck_d & ~csn_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sy  <= '0;
      csn_sy  <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
      csn_d   <= 1'b1;
      sh_q    <= '0;
      bit_q   <= '0;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      tx_q    <= '0;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      csn_sy  <= {csn_sy[0], csn_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      sck_d   <= sck_s;
      csn_d   <= csn_s;
      if (csn_s) begin
        bit_q  <= '0;
        idx_q  <= '0;
        pend_q <= 1'b0;
        tx_q   <= '0;
      end else begin
        if (rise) begin
          sh_q  <= {sh_q[5:0], mosi_s};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            pend_q <= 1'b1;
            if (idx_q != 3'(HDR_BYTES)) idx_q <= idx_q + 3'd1;
          end
        end
        // response byte is loaded on the first falling edge after a byte ends
        if (fall) begin
          if (pend_q) begin
            tx_q   <= tx_byte_i;
            pend_q <= 1'b0;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign byte_o      = {sh_q, mosi_s};
  assign byte_done_o = rise && (bit_q == 3'd7);
  assign load_o      = fall && pend_q;
  assign cs_rise_o   = csn_s & ~csn_d;
  assign aligned_o   = (bit_q == 3'd0);
  assign byte_idx_o  = idx_q;
  assign miso_o      = tx_q[7];
endmodule

// File: rtl/sfc_array.sv
module sfc_array #(
  parameter  int MEM_BYTES  = 1024,
  parameter  int PAGE_BYTES = 256,
  localparam int MEM_AW     = $clog2(MEM_BYTES),
  localparam int PAGE_AW    = $clog2(PAGE_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               buf_clr_i,
  input  logic               buf_we_i,
  input  logic [PAGE_AW-1:0] buf_idx_i,
  input  logic [7:0]         buf_data_i,
  input  logic               start_i,
  input  logic               erase_i,
  input  logic [MEM_AW-1:0]  base_i,
  input  logic [MEM_AW-1:0]  len_m1_i,
  input  logic [MEM_AW-1:0]  rd_addr_i,
  output logic [7:0]         rd_data_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [7:0]            mem_q [MEM_BYTES];
  logic [7:0]            buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic                  busy_q, erase_q;
  logic [MEM_AW-1:0]     ptr_q, cnt_q;
  logic [PAGE_AW-1:0]    pidx;

  assign pidx = ptr_q[PAGE_AW-1:0];

  // the walk over the target region doubles as the busy timer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      vld_q   <= '0;
    end else begin
      if (start_i) begin
        busy_q  <= 1'b1;
        erase_q <= erase_i;
        ptr_q   <= base_i;
        cnt_q   <= len_m1_i;
      end else if (busy_q) begin
        ptr_q <= ptr_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == '0) busy_q <= 1'b0;
      end
      if (buf_clr_i)     vld_q <= '0;
      else if (buf_we_i) vld_q[buf_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (busy_q) begin
      if (erase_q)          mem_q[ptr_q] <= 8'hFF;
      else if (vld_q[pidx]) mem_q[ptr_q] <= mem_q[ptr_q] & buf_q[pidx];
    end
    if (buf_we_i) buf_q[buf_idx_i] <= buf_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;
  assign done_o    = busy_q && (cnt_q == '0);
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl import sfc_pkg::*; #(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int MEM_AW  = $clog2(MEM_BYTES);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int SEC_AW  = $clog2(SECTOR_BYTES);

  logic              cs_rise, byte_done, load, aligned;
  logic [7:0]        byte_b, tx_byte, rd_data, op_in, status;
  logic [2:0]        idx;
  logic              busy, done;
  logic [7:0]        cmd_q;
  logic [MEM_AW-1:0] addr_q;
  logic              wel_q, dp_q;
  logic              whole, can_write, start, erase, buf_clr, buf_we;
  logic [MEM_AW-1:0] base, len_m1;

  sfc_spi_front u_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_i       (sck_i),
    .csn_i       (csn_i),
    .mosi_i      (mosi_i),
    .tx_byte_i   (tx_byte),
    .cs_rise_o   (cs_rise),
    .byte_done_o (byte_done),
    .load_o      (load),
    .aligned_o   (aligned),
    .byte_o      (byte_b),
    .byte_idx_o  (idx),
    .miso_o      (miso_o)
  );

  // opcode filter: power-down admits only release, busy admits only status read
  always_comb begin
    op_in = byte_b;
    if (dp_q)      op_in = (byte_b == OP_RES)  ? OP_RES  : OP_NOP;
    else if (busy) op_in = (byte_b == OP_RDSR) ? OP_RDSR : OP_NOP;
  end

  always_comb begin
    status         = '0;
    status[ST_WIP] = busy;
    status[ST_WEL] = wel_q;
  end

  always_comb begin
    if (cmd_q == OP_RDSR)                                   tx_byte = status;
    else if (cmd_q == OP_READ && idx == 3'(HDR_BYTES))      tx_byte = rd_data;
    else                                                    tx_byte = '0;
  end

  assign whole     = aligned && (idx != 3'd0);
  assign can_write = cs_rise && whole && !busy && !dp_q && wel_q;

  always_comb begin
    start  = 1'b0;
    erase  = 1'b0;
    base   = '0;
    len_m1 = '0;
    if (can_write) begin
      unique case (cmd_q)
        OP_PP: if (idx == 3'(HDR_BYTES)) begin
          start  = 1'b1;
          base   = {addr_q[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
          len_m1 = MEM_AW'(PAGE_BYTES - 1);
        end
        OP_SE: if (idx == 3'(HDR_BYTES)) begin
          start  = 1'b1;
          erase  = 1'b1;
          base   = {addr_q[MEM_AW-1:SEC_AW], {SEC_AW{1'b0}}};
          len_m1 = MEM_AW'(SECTOR_BYTES - 1);
        end
        OP_BE: begin
          start  = 1'b1;
          erase  = 1'b1;
          len_m1 = MEM_AW'(MEM_BYTES - 1);
        end
        default: ;
      endcase
    end
  end

  assign buf_clr = byte_done && (idx == 3'd0) && (op_in == OP_PP);
  assign buf_we  = byte_done && (idx == 3'(HDR_BYTES)) && (cmd_q == OP_PP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= OP_NOP;
      addr_q <= '0;
      wel_q  <= 1'b0;
      dp_q   <= 1'b0;
    end else begin
      if (byte_done) begin
        if (idx == 3'd0)                   cmd_q  <= op_in;
        else if (idx < 3'(HDR_BYTES))      addr_q <= MEM_AW'({addr_q, byte_b});
        else if (cmd_q == OP_PP)           addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + 1'b1;
      end
      if (load && cmd_q == OP_READ && idx == 3'(HDR_BYTES)) addr_q <= addr_q + 1'b1;
      if (cs_rise && whole) begin
        if (dp_q) begin
          if (cmd_q == OP_RES) dp_q <= 1'b0;
        end else if (!busy) begin
          if (cmd_q == OP_WREN) wel_q <= 1'b1;
          if (cmd_q == OP_DP)   dp_q  <= 1'b1;
        end
      end
      if (done) wel_q <= 1'b0;
    end
  end

  sfc_array #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .buf_clr_i  (buf_clr),
    .buf_we_i   (buf_we),
    .buf_idx_i  (addr_q[PAGE_AW-1:0]),
    .buf_data_i (byte_b),
    .start_i    (start),
    .erase_i    (erase),
    .base_i     (base),
    .len_m1_i   (len_m1),
    .rd_addr_i  (addr_q),
    .rd_data_o  (rd_data),
    .busy_o     (busy),
    .done_o     (done)
  );
endmodule

// File: rtl/spi_flash_ctrl_chk.sv
module spi_flash_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wel_q,
  input logic dp_q,
  input logic busy
);
  AST_START_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel_q)); // R5

  AST_BUSY_HOLDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> wel_q); // R6

  AST_END_CLEARS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel_q); // R7

  AST_DP_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_q |-> !busy); // R8

  AST_DP_FREEZES_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_q && $past(dp_q)) |-> $stable(wel_q)); // R8
endmodule

bind spi_flash_ctrl spi_flash_ctrl_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wel_q  (wel_q),
  .dp_q   (dp_q),
  .busy   (busy)
);

// File: tb/spi_flash_ctrl_tb.sv
module spi_flash_ctrl_tb;
  localparam int MEM = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic csn = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  logic [7:0] exp_mem [MEM];

  always #10 clk = ~clk;

  spi_flash_ctrl u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sck_i  (sck),
    .csn_i  (csn),
    .mosi_i (mosi),
    .miso_o (miso)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wait_clk(4);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cs_lo();
    csn = 1'b0;
    wait_clk(4);
  endtask

  task automatic cs_hi();
    wait_clk(2);
    csn = 1'b1;
    wait_clk(8);
  endtask

  task automatic send_op(input logic [7:0] op);
    logic [7:0] d;
    cs_lo();
    xfer(op, d);
    cs_hi();
  endtask

  task automatic send_addr(input int a);
    logic [7:0] d;
    xfer(8'(a >> 16), d);
    xfer(8'(a >> 8), d);
    xfer(8'(a), d);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_lo();
    xfer(8'h05, d);
    xfer(8'h00, st);
    cs_hi();
  endtask

  task automatic wait_idle(input string rq);
    logic [7:0] st;
    int n = 0;
    do begin
      rdsr(st);
      n++;
    end while (st[0] && n < 200);
    check(rq, st, 8'h00);
  endtask

  task automatic prog(input int a, input int n, input int mul, input int add, input bit apply);
    logic [7:0] d, r;
    int idx;
    cs_lo();
    xfer(8'h02, r);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'((i * mul + add) & 255);
      xfer(d, r);
      if (apply) begin
        idx = ((a & ~255) | ((a + i) & 255)) % MEM;
        exp_mem[idx] = exp_mem[idx] & d;
      end
    end
    cs_hi();
  endtask

  task automatic read_chk(input int a, input int n, input string rq);
    logic [7:0] r;
    cs_lo();
    xfer(8'h03, r);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      check(rq, r, exp_mem[(a + i) % MEM]);
    end
    cs_hi();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R2: reset status
    rdsr(st); check("R2", st, 8'h00);

    // R1: partial opcode then deselect
    cs_lo(); xbits(8'h06, 4, d); cs_hi();
    rdsr(st); check("R1", st, 8'h00);

    // R5: erase without latch
    send_op(8'hC7);
    rdsr(st); check("R5", st, 8'h00);

    // R2: latch set, status repeats within one frame
    send_op(8'h06);
    cs_lo(); xfer(8'h05, d);
    xfer(8'h00, st); check("R2", st, 8'h02);
    xfer(8'h00, st); check("R2", st, 8'h02);
    cs_hi();

    // R6: whole-array erase busy, power-down ignored while busy
    send_op(8'hC7);
    rdsr(st); check("R6", st, 8'h03);
    send_op(8'hB9);
    wait_idle("R7");
    send_op(8'h06);
    rdsr(st); check("R6", st, 8'h02);
    for (int i = 0; i < MEM; i++) exp_mem[i] = 8'hFF;
    read_chk(0, MEM, "R4");

    // R3: program with page wrap, then AND with a second program
    prog(32'h0F0, 32, 37, 5, 1'b1);
    rdsr(st); check("R6", st, 8'h03);
    wait_idle("R7");
    send_op(8'h06);
    prog(32'h0F8, 16, 11, 8'h3C, 1'b1);
    wait_idle("R7");
    read_chk(0, 256, "R3");

    // R5: program without latch
    prog(32'h100, 4, 0, 0, 1'b0);
    rdsr(st); check("R5", st, 8'h00);
    read_chk(32'h100, 4, "R5");

    // R9: misaligned deselect discards program and erase
    send_op(8'h06);
    cs_lo(); xfer(8'h02, d); send_addr(32'h100); xfer(8'h00, d); xbits(8'h00, 3, d); cs_hi();
    rdsr(st); check("R9", st, 8'h02);
    read_chk(32'h100, 2, "R9");
    cs_lo(); xfer(8'hD8, d); send_addr(32'h000); xbits(8'h00, 5, d); cs_hi();
    rdsr(st); check("R9", st, 8'h02);
    read_chk(32'h0F0, 2, "R9");

    // R4: sector erase clears only its own sector
    prog(32'h1FE, 2, 8'h65, 8'h5A, 1'b1);
    wait_idle("R7");
    send_op(8'h06);
    prog(32'h200, 2, 3, 8'h12, 1'b1);
    wait_idle("R7");
    read_chk(32'h200, 2, "R3");
    send_op(8'h06);
    cs_lo(); xfer(8'hD8, d); send_addr(32'h3FF); cs_hi();
    rdsr(st); check("R6", st, 8'h03);
    wait_idle("R7");
    for (int i = 32'h200; i < 32'h400; i++) exp_mem[i] = 8'hFF;
    read_chk(32'h1FC, 8, "R4");
    read_chk(32'h3FC, 4, "R4");

    // R8: deep power-down
    send_op(8'h06);
    send_op(8'hB9);
    rdsr(st); check("R8", st, 8'h00);
    prog(32'h000, 1, 0, 0, 1'b0);
    send_op(8'hAB);
    rdsr(st); check("R8", st, 8'h02);
    read_chk(32'h000, 1, "R8");

    // R10: read wraps at end of array
    read_chk(32'h3FE, 4, "R10");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule